// File: doc/BRIEF.md
# Masked Fast GPIO Port

This block is a 32-pin general-purpose I/O port that sits on a simple word-wide register bus. It has a direction register, a mask register and an output latch. Three access windows act on the latch and the pins: a pin-value window, a set window and a clear window. The mask applies to every one of these windows. Software can therefore change or observe any chosen group of pins in one bus write, with no read-modify-write sequence.

Each pin's output enable follows its direction bit, and each pin's output value follows its latch bit. Pin inputs go through a two-flop synchroniser before they reach the pin-value window. Register reads are combinational from the address. A write takes effect on the clock edge that samples the write strobe.

The asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `masked_gpio_port`

## Requirements
- R1: After reset, the direction, mask and output latch are all zero, so pin_oe and pin_out are zero and every readable offset returns 0.
- R2: Offset 0x00 is the direction register, readable and writable. pin_oe bit n equals direction bit n, where 1 means the pin is an output.
- R3: Offset 0x10 is the mask register, readable and writable. A mask bit of 1 excludes that pin from set, clear, pin-write and pin-read operations.
- R4: A write to offset 0x18 sets each latch bit whose data bit is 1 and whose mask bit is 0. Data bits of 0 and masked bits leave the latch unchanged.
- R5: A write to offset 0x1C clears each latch bit whose data bit is 1 and whose mask bit is 0. Data bits of 0 and masked bits leave the latch unchanged.
- R6: A write to offset 0x14 loads the written value into every latch bit whose mask bit is 0. Masked latch bits keep their value.
- R7: A read of offset 0x14 returns the synchronised pin inputs ANDed with the inverted mask, whatever the direction setting. Masked bits read as 0.
- R8: A read of offset 0x18 returns the whole output latch, without masking.
- R9: A read of offset 0x1C or of any unmapped offset returns 0. A write to an unmapped offset changes no register.
- R10: A change on pin_in shows in the pin read after two rising clock edges, and not after one.
- R11: pin_out bit n equals output latch bit n. It changes on the edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |

## Verification
A register write is due one rising edge after the strobe. The bench drives the write on a falling edge and reads it back on the next falling edge, after that single rising edge. Read data is combinational, so each read is sampled 1 ns after its address is driven, with no clock edge between them. A pin change is due two edges later. The bench changes pin_in on a falling edge, shows that the old value remains after one edge, and shows that the new value is present after the second.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_PIN  = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_SET  = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 5'h1C;

  typedef struct packed {
    logic dir;
    logic mask;
    logic pin;
    logic set;
    logic clr;
  } reg_sel_t;

  function automatic reg_sel_t decode_ofs(logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s.dir  = (a == OFS_DIR);
    s.mask = (a == OFS_MASK);
    s.pin  = (a == OFS_PIN);
    s.set  = (a == OFS_SET);
    s.clr  = (a == OFS_CLR);
    return s;
  endfunction
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= raw_in;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk2
      logic [1:0] warm_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      end
      assert_sync_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_out == $past(raw_in, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  reg_sel_t         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] latch_q
);
  logic [WIDTH-1:0] dir_d, mask_d, latch_d, open_bits;
  logic dir_en, mask_en, latch_en;

  assign open_bits = wdata & ~mask_q;
  assign dir_en    = wr & sel.dir;
  assign mask_en   = wr & sel.mask;
  assign latch_en  = wr & (sel.set | sel.clr | sel.pin);

  always_comb begin
    dir_d   = wdata;
    mask_d  = wdata;
    latch_d = latch_q;
    if (sel.set)      latch_d = latch_q | open_bits;
    else if (sel.clr) latch_d = latch_q & ~open_bits;
    else if (sel.pin) latch_d = (latch_q & mask_q) | open_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      mask_q  <= '0;
      latch_q <= '0;
    end else begin
      if (dir_en)   dir_q   <= dir_d;
      if (mask_en)  mask_q  <= mask_d;
      if (latch_en) latch_q <= latch_d;
    end
  end

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel.mask) |=> (mask_q == $past(wdata)));
  assert_set_no_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel.set) |=> (($past(latch_q) & ~latch_q) == '0));
  assert_clr_no_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel.clr) |=> ((latch_q & ~$past(latch_q)) == '0));
  assert_masked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel.set || sel.clr || sel.pin)) |=>
      (((latch_q ^ $past(latch_q)) & $past(mask_q)) == '0));
  assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (sel == '0)) |=> ($stable(dir_q) && $stable(mask_q) && $stable(latch_q)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  dir_q,
  input  logic [WIDTH-1:0]  mask_q,
  input  logic [WIDTH-1:0]  latch_q,
  input  logic [WIDTH-1:0]  pins_sync,
  output logic [WIDTH-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (addr == OFS_DIR)       rdata = dir_q;
    else if (addr == OFS_MASK) rdata = mask_q;
    else if (addr == OFS_PIN)  rdata = pins_sync & ~mask_q;
    else if (addr == OFS_SET)  rdata = latch_q;
  end
endmodule

// File: rtl/masked_gpio_port.sv
module masked_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  logic rst_meta_q, rst_core_n;
  logic [WIDTH-1:0] dir_q, mask_q, latch_q, pins_sync;
  reg_sel_t sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  assign sel = decode_ofs(bus_addr);

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_core_n), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .dir_q(dir_q), .mask_q(mask_q), .latch_q(latch_q)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .raw_in(pin_in), .sync_out(pins_sync)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_rmux (
    .addr(bus_addr), .dir_q(dir_q), .mask_q(mask_q), .latch_q(latch_q),
    .pins_sync(pins_sync), .rdata(bus_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = latch_q;

  assert_pin_read_masked_R7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == OFS_PIN) |-> ((bus_rdata & mask_q) == '0));
  assert_clr_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_addr == OFS_CLR) |-> (bus_rdata == '0));
  assert_out_follows_set_R11: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && sel.set) |=> ((pin_out & ($past(bus_wdata) & ~$past(mask_q))) ==
                             ($past(bus_wdata) & ~$past(mask_q))));
endmodule

// File: tb/tb_masked_gpio_port.sv
module tb_masked_gpio_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, pin_in, pin_out, pin_oe;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  masked_gpio_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(string req, logic [4:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_check("R1 dir", 5'h00, 0);
    rd_check("R1 mask", 5'h10, 0);
    rd_check("R1 set", 5'h18, 0);
    rd_check("R1 pin", 5'h14, 0);
    check("R1 oe", pin_oe, 0);
    check("R1 out", pin_out, 0);
  endtask

  task automatic t_dir;
    wr(5'h00, 32'hA5A5_0F0F);
    rd_check("R2 dir read", 5'h00, 32'hA5A5_0F0F);
    check("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
  endtask

  task automatic t_mask;
    wr(5'h10, 32'h1234_8001);
    rd_check("R3 mask read", 5'h10, 32'h1234_8001);
    wr(5'h10, 32'h0);
  endtask

  task automatic t_set;
    wr(5'h18, 32'h0000_00FF);
    rd_check("R4 set", 5'h18, 32'h0000_00FF);
    wr(5'h18, 32'h0);
    rd_check("R4 zero no effect", 5'h18, 32'h0000_00FF);
    wr(5'h10, 32'hFFFF_0000);
    wr(5'h18, 32'hFFFF_FFFF);
    rd_check("R4 masked set / R8", 5'h18, 32'h0000_FFFF);
    check("R11 pin_out", pin_out, 32'h0000_FFFF);
  endtask

  task automatic t_clear;
    wr(5'h10, 32'h0000_00F0);
    wr(5'h1C, 32'h0);
    rd_check("R5 zero no effect", 5'h18, 32'h0000_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd_check("R5 masked clear", 5'h18, 32'h0000_00F0);
    rd_check("R9 clr reads 0", 5'h1C, 0);
  endtask

  task automatic t_pinwrite;
    wr(5'h10, 32'hFF00_FF00);
    wr(5'h14, 32'h1234_5678);
    rd_check("R6 pin write", 5'h18, 32'h0034_0078);
    check("R11 pin_out", pin_out, 32'h0034_0078);
  endtask

  task automatic t_pinread;
    wr(5'h10, 32'h0);
    wr(5'h00, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0;
    repeat (3) @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd_check("R10 not after one edge", 5'h14, 32'h0);
    @(negedge clk);
    rd_check("R10 after two edges / R7", 5'h14, 32'hDEAD_BEEF);
    wr(5'h10, 32'h0000_FFFF);
    rd_check("R7 masked read", 5'h14, 32'hDEAD_0000);
    wr(5'h00, 32'h0);
    rd_check("R7 input direction", 5'h14, 32'hDEAD_0000);
  endtask

  task automatic t_unmapped;
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h0000_0003);
    wr(5'h18, 32'h0000_0100);
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd_check("R9 dir kept", 5'h00, 32'h0000_0003);
    rd_check("R9 mask kept", 5'h10, 32'h0);
    rd_check("R9 latch kept", 5'h18, 32'h0034_0178);
    rd_check("R9 unmapped read", 5'h04, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_dir;
    t_mask;
    t_set;
    t_clear;
    t_pinwrite;
    t_pinread;
    t_unmapped;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule